// File: doc/BRIEF.md
# Composite Video Sync Generator

This block produces the active-low composite sync waveform for one progressive, PAL-style analog frame, timed in cycles of a 24 MHz clock. A state counter walks the frame in a fixed order. First come broad half-lines, where sync stays low for most of the 32 µs slot. Then come equalizing half-lines, with only a short low pulse at the start of each slot. Then comes a single picture state that runs a set of full-length lines, each with a horizontal sync pulse and a back porch. Last comes a closing group of equalizing half-lines, after which the counter wraps to the first broad half-line.

Besides sync, the block gives a pixel shifter a line-active qualifier for the visible part of each picture line. It also gives a trigger output for an oscilloscope that is high once per frame, a one-clock frame-start strobe, and the index of the picture line in progress. Every timing value and every group size is a parameter. The defaults give 10 broad, 10 leading equalizing, 304 picture and 12 trailing equalizing slots. A 768-clock half-line uses a 720-clock broad low and a 48-clock equalizing low. A 1536-clock line uses a 113-clock horizontal sync and a 137-clock back porch. All outputs are registered, so each output shows the frame position of the previous clock.

Top module: `csync_gen`

## Requirements
- R1: While reset is asserted, sync_n is 1 and dbg_trig, line_active, frame_start and line_idx are all 0. After reset is released, the first frame begins within 8 clocks.
- R2: A frame is N_BROAD broad slots, then N_EQ_PRE equalizing slots, then LINES picture lines, then N_EQ_POST equalizing slots. It then repeats from the first broad slot. A state past the final equalizing slot, whether reached by counting or by upset, returns to the first broad slot on the next clock.
- R3: In a broad slot, sync_n is 0 for the first BROAD_LOW clocks and 1 for the remaining SLOT_CLKS-BROAD_LOW clocks.
- R4: In an equalizing slot, sync_n is 0 for the first EQ_LOW clocks and 1 for the remaining clocks of the slot.
- R5: In a picture line of LINE_CLKS clocks, sync_n is 0 for the first HSYNC clocks and 1 for the rest. line_active is 1 from clock HSYNC+PORCH to the end of the line.
- R6: During picture line n (0-based), line_idx equals n. Outside the picture region, line_idx is 0. Within the picture region it only ever advances by one.
- R7: The first trailing equalizing pulse starts on the clock right after the last clock of the last picture line, with no gap.
- R8: dbg_trig is 1 for exactly the first broad slot of each frame. frame_start is 1 for one clock, the first clock of each frame.
- R9: line_active is 0 everywhere outside picture lines, and sync_n is never 0 while line_active is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (24 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_n | output | 1 | Composite sync, low while a pulse is active |
| dbg_trig | output | 1 | Once-per-frame trigger, high through the first broad slot |
| line_active | output | 1 | High during the visible part of a picture line |
| frame_start | output | 1 | One-clock strobe on the first clock of a frame |
| line_idx | output | IDX_W | Index of the current picture line, 0 outside the picture region |

## Verification
On every clock, the assertions check these properties: frame_start is a single-clock pulse that always coincides with dbg_trig, sync is never low while line_active is high, line_idx only steps upward by one, and no low run of sync or high run of dbg_trig is longer than its longest legal length. The exact pulse widths, the order of the slot groups, the gapless handover from the last picture line to the closing equalizing pulse, the frame repeat and the reset values are shown only by the bench. It compares every output on every clock of two whole frames against a timeline computed from the requirements, then resets the block in the middle of a run.

// File: rtl/csync_pkg.sv
package csync_pkg;

  // Kind of slot the sequencer is currently in
  typedef enum logic [1:0] {
    SK_BROAD = 2'd0,
    SK_EQUAL = 2'd1,
    SK_PICT  = 2'd2
  } slot_kind_e;

  // Per-clock output bundle computed before the output register
  typedef struct packed {
    logic sync_n;
    logic trig;
    logic active;
    logic fstart;
  } wave_t;

  localparam wave_t WAVE_IDLE = '{sync_n: 1'b1, trig: 1'b0, active: 1'b0, fstart: 1'b0};

endpackage

// File: rtl/csync_seq.sv
module csync_seq #(
  parameter int SLOT_CLKS = 768,
  parameter int LINE_CLKS = 1536,
  parameter int LINES     = 304,
  parameter int N_BROAD   = 10,
  parameter int N_EQ_PRE  = 10,
  parameter int N_EQ_POST = 12,
  parameter int POS_W     = 11,
  parameter int ST_W      = 6,
  parameter int LN_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  output logic [ST_W-1:0]  state_o,
  output logic [POS_W-1:0] pos_o,
  output logic [LN_W-1:0]  line_o
);

  localparam int               ST_PICT_I = N_BROAD + N_EQ_PRE;
  localparam logic [ST_W-1:0]  ST_PICT   = ST_W'(ST_PICT_I);
  localparam logic [ST_W-1:0]  ST_LAST   = ST_W'(ST_PICT_I + N_EQ_POST);
  localparam logic [POS_W-1:0] SLOT_END  = POS_W'(SLOT_CLKS - 1);
  localparam logic [POS_W-1:0] LINE_END  = POS_W'(LINE_CLKS - 1);
  localparam logic [LN_W-1:0]  LN_END    = LN_W'(LINES - 1);

  logic [ST_W-1:0]  state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [LN_W-1:0]  line_q, line_d;
  logic             in_pict, slot_done;

  assign in_pict   = (state_q == ST_PICT);
  assign slot_done = in_pict ? (pos_q == LINE_END) : (pos_q == SLOT_END);

  // next-state process
  always_comb begin
    state_d = state_q;
    pos_d   = pos_q + POS_W'(1);
    line_d  = line_q;
    if (state_q > ST_LAST) begin
      // out-of-range state: restart at first broad slot
      state_d = '0;
      pos_d   = '0;
      line_d  = '0;
    end else if (slot_done) begin
      pos_d = '0;
      if (in_pict) begin
        if (line_q == LN_END) begin
          line_d  = '0;
          state_d = state_q + ST_W'(1);
        end else begin
          line_d = line_q + LN_W'(1);
        end
      end else if (state_q == ST_LAST) begin
        state_d = '0;
      end else begin
        state_d = state_q + ST_W'(1);
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      pos_q   <= '0;
      line_q  <= '0;
    end else if (adv_en) begin
      state_q <= state_d;
      pos_q   <= pos_d;
      line_q  <= line_d;
    end
  end

  assign state_o = state_q;
  assign pos_o   = pos_q;
  assign line_o  = line_q;

endmodule

// File: rtl/csync_decode.sv
module csync_decode
  import csync_pkg::*;
#(
  parameter int N_BROAD   = 10,
  parameter int N_EQ_PRE  = 10,
  parameter int BROAD_LOW = 720,
  parameter int EQ_LOW    = 48,
  parameter int HSYNC     = 113,
  parameter int PORCH     = 137,
  parameter int POS_W     = 11,
  parameter int ST_W      = 6
) (
  input  logic [ST_W-1:0]  state_i,
  input  logic [POS_W-1:0] pos_i,
  output wave_t            wave_o,
  output logic             pict_o
);

  localparam logic [ST_W-1:0]  ST_BROAD_END = ST_W'(N_BROAD);
  localparam logic [ST_W-1:0]  ST_PICT      = ST_W'(N_BROAD + N_EQ_PRE);
  localparam logic [POS_W-1:0] P_BROAD      = POS_W'(BROAD_LOW);
  localparam logic [POS_W-1:0] P_EQ         = POS_W'(EQ_LOW);
  localparam logic [POS_W-1:0] P_HS         = POS_W'(HSYNC);
  localparam logic [POS_W-1:0] P_VIS        = POS_W'(HSYNC + PORCH);

  slot_kind_e kind;

  always_comb begin
    if (state_i < ST_BROAD_END)  kind = SK_BROAD;
    else if (state_i == ST_PICT) kind = SK_PICT;
    else                         kind = SK_EQUAL;
  end

  always_comb begin
    wave_o        = WAVE_IDLE;
    wave_o.trig   = (state_i == '0);
    wave_o.fstart = (state_i == '0) && (pos_i == '0);
    unique case (kind)
      SK_BROAD: wave_o.sync_n = (pos_i >= P_BROAD);
      SK_PICT: begin
        wave_o.sync_n = (pos_i >= P_HS);
        wave_o.active = (pos_i >= P_VIS);
      end
      default:  wave_o.sync_n = (pos_i >= P_EQ);
    endcase
  end

  assign pict_o = (kind == SK_PICT);

endmodule

// File: rtl/csync_gen.sv
module csync_gen
  import csync_pkg::*;
#(
  parameter int SLOT_CLKS   = 768,
  parameter int BROAD_LOW   = 720,
  parameter int EQ_LOW      = 48,
  parameter int LINE_CLKS   = 1536,
  parameter int HSYNC       = 113,
  parameter int PORCH       = 137,
  parameter int LINES       = 304,
  parameter int N_BROAD     = 10,
  parameter int N_EQ_PRE    = 10,
  parameter int N_EQ_POST   = 12,
  parameter int IDX_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             sync_n,
  output logic             dbg_trig,
  output logic             line_active,
  output logic             frame_start,
  output logic [IDX_W-1:0] line_idx
);

  localparam int POS_W = $clog2((LINE_CLKS > SLOT_CLKS) ? LINE_CLKS : SLOT_CLKS);
  localparam int ST_W  = $clog2(N_BROAD + N_EQ_PRE + N_EQ_POST + 2);
  localparam int LN_W  = $clog2(LINES);

  // reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_chain;
  logic                   rst_int_n;

  generate
    if (SYNC_STAGES == 1) begin : g_rst1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_chain <= '0;
        else        rst_chain <= 1'b1;
      end
    end else begin : g_rstn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_chain <= '0;
        else        rst_chain <= {rst_chain[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_chain[SYNC_STAGES-1];

  logic [ST_W-1:0]  state;
  logic [POS_W-1:0] pos;
  logic [LN_W-1:0]  line;
  wave_t            wave_d, wave_q;
  logic             pict;
  logic [IDX_W-1:0] idx_d, idx_q;
  logic             run_en;

  assign run_en = 1'b1;

  csync_seq #(
    .SLOT_CLKS (SLOT_CLKS),
    .LINE_CLKS (LINE_CLKS),
    .LINES     (LINES),
    .N_BROAD   (N_BROAD),
    .N_EQ_PRE  (N_EQ_PRE),
    .N_EQ_POST (N_EQ_POST),
    .POS_W     (POS_W),
    .ST_W      (ST_W),
    .LN_W      (LN_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .adv_en  (run_en),
    .state_o (state),
    .pos_o   (pos),
    .line_o  (line)
  );

  csync_decode #(
    .N_BROAD   (N_BROAD),
    .N_EQ_PRE  (N_EQ_PRE),
    .BROAD_LOW (BROAD_LOW),
    .EQ_LOW    (EQ_LOW),
    .HSYNC     (HSYNC),
    .PORCH     (PORCH),
    .POS_W     (POS_W),
    .ST_W      (ST_W)
  ) u_dec (
    .state_i (state),
    .pos_i   (pos),
    .wave_o  (wave_d),
    .pict_o  (pict)
  );

  assign idx_d = pict ? IDX_W'(line) : '0;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wave_q <= WAVE_IDLE;
      idx_q  <= '0;
    end else if (run_en) begin
      wave_q <= wave_d;
      idx_q  <= idx_d;
    end
  end

  assign sync_n      = wave_q.sync_n;
  assign dbg_trig    = wave_q.trig;
  assign line_active = wave_q.active;
  assign frame_start = wave_q.fstart;
  assign line_idx    = idx_q;

endmodule

// File: rtl/csync_checker.sv
module csync_checker #(
  parameter int SLOT_CLKS = 768,
  parameter int BROAD_LOW = 720,
  parameter int IDX_W     = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_n,
  input logic             dbg_trig,
  input logic             line_active,
  input logic             frame_start,
  input logic [IDX_W-1:0] line_idx
);

  logic [31:0] low_run;
  logic [31:0] trig_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      trig_run <= '0;
    end else begin
      low_run  <= sync_n   ? 32'd0 : low_run + 32'd1;
      trig_run <= dbg_trig ? trig_run + 32'd1 : 32'd0;
    end
  end

  // R3: no sync low run exceeds the broad-pulse width
  p_low_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 32'(BROAD_LOW));

  // R8: trigger never lasts longer than one half-line slot
  p_trig_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_run <= 32'(SLOT_CLKS));

  // R8: frame start lasts a single clock
  p_fstart_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R8: frame start lies inside the trigger window
  p_fstart_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> dbg_trig);

  // R9: no sync pulse during the visible part of a line
  p_active_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_active |-> sync_n);

  // R9: visible region never overlaps the first broad slot
  p_active_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_active |-> !dbg_trig);

  // R6: line index only ever steps up by one
  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(line_idx) && (line_idx != '0)) |-> (line_idx == $past(line_idx) + IDX_W'(1)));

endmodule

bind csync_gen csync_checker #(
  .SLOT_CLKS (SLOT_CLKS),
  .BROAD_LOW (BROAD_LOW),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_n      (sync_n),
  .dbg_trig    (dbg_trig),
  .line_active (line_active),
  .frame_start (frame_start),
  .line_idx    (line_idx)
);

// File: tb/sim_csync_gen.sv
`timescale 1ns/1ps
module sim_csync_gen;

  localparam int SLOT  = 16;
  localparam int BLOW  = 12;
  localparam int ELOW  = 3;
  localparam int LINE  = 32;
  localparam int HS    = 4;
  localparam int PO    = 5;
  localparam int NL    = 6;
  localparam int NB    = 10;
  localparam int NE1   = 10;
  localparam int NE2   = 12;
  localparam int PRE   = (NB + NE1) * SLOT;
  localparam int PEND  = PRE + NL * LINE;
  localparam int FRAME = PEND + NE2 * SLOT;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_n, dbg_trig, line_active, frame_start;
  logic [8:0] line_idx;

  always #2.5 clk = ~clk;

  csync_gen #(
    .SLOT_CLKS (SLOT), .BROAD_LOW (BLOW), .EQ_LOW (ELOW),
    .LINE_CLKS (LINE), .HSYNC (HS), .PORCH (PO), .LINES (NL),
    .N_BROAD (NB), .N_EQ_PRE (NE1), .N_EQ_POST (NE2), .IDX_W (9),
    .SYNC_STAGES (2)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .sync_n (sync_n), .dbg_trig (dbg_trig),
    .line_active (line_active), .frame_start (frame_start), .line_idx (line_idx)
  );

  typedef struct {
    int    s, d, a, f, idx;
    string ts, ta, tf;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   go = 1'b0;
  bit   mon_done = 1'b0;
  bit   ended = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic exp_t model(int t);
    exp_t e;
    int o;
    e.s = 1; e.d = 0; e.a = 0; e.idx = 0;
    e.f  = (t == 0) ? 1 : 0;
    e.tf = (t == 0) ? "R2" : "R8";
    e.ta = "R9";
    if (t < PRE) begin
      o   = t % SLOT;
      e.d = (t < SLOT) ? 1 : 0;
      if (t / SLOT < NB) begin e.s = (o >= BLOW) ? 1 : 0; e.ts = "R3"; end
      else               begin e.s = (o >= ELOW) ? 1 : 0; e.ts = "R4"; end
    end else if (t < PEND) begin
      o     = (t - PRE) % LINE;
      e.idx = (t - PRE) / LINE;
      e.s   = (o >= HS) ? 1 : 0;
      e.a   = (o >= HS + PO) ? 1 : 0;
      e.ts  = "R5";
      e.ta  = "R5";
    end else begin
      o    = (t - PEND) % SLOT;
      e.s  = (o >= ELOW) ? 1 : 0;
      e.ts = (t == PEND) ? "R7" : "R4";
    end
    return e;
  endfunction

  task automatic push_frame();
    for (int t = 0; t < FRAME; t++) sb.push_back(model(t));
  endtask

  task automatic check_reset_state();
    chk("R1", "sync_n", int'(sync_n), 1);
    chk("R1", "dbg_trig", int'(dbg_trig), 0);
    chk("R1", "line_active", int'(line_active), 0);
    chk("R1", "frame_start", int'(frame_start), 0);
    chk("R1", "line_idx", int'(line_idx), 0);
  endtask

  // monitor: pops one expected item per clock and compares
  initial begin
    exp_t e;
    wait (go);
    while (sb.size() > 0) begin
      e = sb.pop_front();
      chk(e.ts, "sync_n", int'(sync_n), e.s);
      chk("R8", "dbg_trig", int'(dbg_trig), e.d);
      chk(e.ta, "line_active", int'(line_active), e.a);
      chk(e.tf, "frame_start", int'(frame_start), e.f);
      chk("R6", "line_idx", int'(line_idx), e.idx);
      @(negedge clk);
    end
    mon_done = 1'b1;
  end

  // driver and sequence
  initial begin
    int waited;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    waited = 0;
    @(negedge clk);
    while (!frame_start && waited < 8) begin
      waited++;
      @(negedge clk);
    end
    chk("R1", "frame start after reset", int'(frame_start), 1);
    push_frame();
    push_frame();
    go = 1'b1;
    wait (mon_done);
    // R2: the third frame starts right after two full frames
    chk("R2", "frame_start on third frame", int'(frame_start), 1);
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    repeat (3) @(negedge clk);
    check_reset_state();
    finish_run();
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule